// File: doc/BRIEF.md
# Direct-Page Single-Bit Test, Branch and Set Sequencer

This block carries out one single-bit instruction on a byte held in the first 256 bytes of the address space. On a start pulse it takes an opcode, a one-byte direct address, a signed displacement, the address of the instruction and the current carry flag. It then reads the addressed byte through a synchronous memory port. For the two branch forms it tests one bit, loads that bit into carry and chooses the following program counter. For the set form it writes the byte back with one bit forced to one.

The opcode encodes both the bit number and the kind of operation, so no separate bit-select input is needed. The bit number sits in opcode bits [3:1]. A branch form stops after five cycles and a set form after four, counting the start cycle as the first. Completion is marked by a one-cycle done pulse, and the new program counter and carry are then held until the next operation overwrites them.

Top module: `bitop_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, done, mem_rd and mem_wr are 0, and next_pc and carry_out are 0.
- R2: Opcodes 0x00 to 0x0F are branch forms that test bit n = opcode[3:1]. If opcode[0] is 0 the branch is taken when that bit is 1. If opcode[0] is 1 the branch is taken when that bit is 0.
- R3: A taken branch gives next_pc = pc_in + 3 + sign-extended disp. A branch that is not taken gives next_pc = pc_in + 3. Both results wrap modulo 2^16.
- R4: A branch form sets carry_out to the tested memory bit.
- R5: A branch form raises done for exactly one cycle, in the fifth cycle (the start cycle is cycle 1). It issues one read and no write.
- R6: Even opcodes 0x10 to 0x1E write the addressed byte back with bit n = opcode[3:1] set and all other bits unchanged. The write happens in cycle 3. done rises in cycle 4, with next_pc = pc_in + 2 and carry_out = carry_in.
- R7: Every operation issues exactly one read, in cycle 2, at address {8'h00, dir_addr}. The read data is used in the following cycle, and a read and a write never happen in the same cycle.
- R8: A start with any other opcode (odd 0x11 to 0x1F, or 0x20 to 0xFF) is ignored: no memory access, no done and no change to next_pc or carry_out. A start raised while an operation is running is also ignored.
- R9: After done, next_pc and carry_out keep their values until the next accepted operation updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the operands below |
| opcode | input | 8 | Operation and bit number |
| dir_addr | input | 8 | Direct-page byte address |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Address of the instruction |
| carry_in | input | 1 | Current carry flag |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data arrives one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| next_pc | output | 16 | Following program counter |
| carry_out | output | 1 | Updated carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit program counter, an 8-bit data word and an 8-bit page offset, with five-cycle branches and four-cycle sets. At these sizes a program counter near 0xFFFF, or near zero with a negative displacement, makes both wrap directions reachable with a single operation. Every bit position can be walked for all three operation kinds, with the tested bit both set and clear. The exact cycle counts of 5 and 4 can be measured directly against done.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   localparam int OPC_W   = 8;
   localparam int BITNO_W = 3;

   typedef enum logic [1:0] {
      BOP_NONE  = 2'd0,
      BOP_BRSET = 2'd1,
      BOP_BRCLR = 2'd2,
      BOP_SETB  = 2'd3
   } bop_kind_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic [OPC_W-1:0]   opcode,
   output bop_kind_e          kind,
   output logic [BITNO_W-1:0] bit_no
);
   always_comb begin
      bit_no = opcode[BITNO_W:1];
      kind   = BOP_NONE;
      if (opcode[7:4] == 4'h0) begin
         kind = opcode[0] ? BOP_BRCLR : BOP_BRSET;
      end else if (opcode[7:4] == 4'h1 && !opcode[0]) begin
         kind = BOP_SETB;
      end
   end
endmodule

// File: rtl/bitop_lane.sv
module bitop_lane
   import bitop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]  word,
   input  logic [BITNO_W-1:0] bit_no,
   output logic [DATA_W-1:0]  mask,
   output logic               bit_val
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i < (1 << BITNO_W)) begin : g_sel
         assign mask[i] = (bit_no == BITNO_W'(i));
      end else begin : g_out
         assign mask[i] = 1'b0;
      end
   end

   assign bit_val = |(word & mask);
endmodule

// File: rtl/bitop_pc_calc.sv
module bitop_pc_calc #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8,
   parameter int LEN_W  = 3
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] tgt_pc
);
   logic [ADDR_W-1:0] disp_ext;

   if (DISP_W < ADDR_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
   end

   assign seq_pc = pc + ADDR_W'(len);
   assign tgt_pc = seq_pc + disp_ext;
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
   import bitop_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int PAGE_W     = 8,
   parameter int DISP_W     = 8,
   parameter int BR_CYCLES  = 5,
   parameter int SET_CYCLES = 4,
   parameter int BR_LEN     = 3,
   parameter int SET_LEN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [PAGE_W-1:0] dir_addr,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              carry_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] next_pc,
   output logic              carry_out,
   output logic              done
);
   localparam int MAX_CYC = (BR_CYCLES > SET_CYCLES) ? BR_CYCLES : SET_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam int MAX_LEN = (BR_LEN > SET_LEN) ? BR_LEN : SET_LEN;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] BR_LAST  = CNT_W'(BR_CYCLES - 1);
   localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SET_CYCLES - 1);
   localparam logic [CNT_W-1:0] RD_CNT   = CNT_W'(1);
   localparam logic [CNT_W-1:0] CAP_CNT  = CNT_W'(2);

   if (BR_CYCLES < 4 || SET_CYCLES < 4) begin : g_bad_cycles
      $error("bitop_seq: operations need at least four cycles");
   end
   if (ADDR_W <= PAGE_W) begin : g_bad_page
      $error("bitop_seq: page offset must be narrower than the address");
   end
   if (DATA_W < (1 << BITNO_W)) begin : g_bad_data
      $error("bitop_seq: data word narrower than the bit-number range");
   end
   if (DISP_W > ADDR_W) begin : g_bad_disp
      $error("bitop_seq: displacement wider than the address");
   end

   bop_kind_e         kind_d, kind_q;
   logic [BITNO_W-1:0] bit_d, bit_q;
   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PAGE_W-1:0] addr_q;
   logic [DISP_W-1:0] disp_q;
   logic [ADDR_W-1:0] pc_q;
   logic              cin_q;
   logic [ADDR_W-1:0] npc_q;
   logic              carry_q;

   logic              accept;
   logic [CNT_W-1:0]  last_cnt;
   logic [DATA_W-1:0] mask;
   logic              bit_val;
   logic              taken;
   logic [LEN_W-1:0]  len;
   logic [ADDR_W-1:0] seq_pc, tgt_pc;

   bitop_decode i_decode (
      .opcode (opcode),
      .kind   (kind_d),
      .bit_no (bit_d)
   );

   bitop_lane #(.DATA_W(DATA_W)) i_lane (
      .word    (mem_rdata),
      .bit_no  (bit_q),
      .mask    (mask),
      .bit_val (bit_val)
   );

   assign len = (kind_q == BOP_SETB) ? LEN_W'(SET_LEN) : LEN_W'(BR_LEN);

   bitop_pc_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) i_pc (
      .pc     (pc_q),
      .disp   (disp_q),
      .len    (len),
      .seq_pc (seq_pc),
      .tgt_pc (tgt_pc)
   );

   assign accept   = start && !busy_q && (kind_d != BOP_NONE);
   assign last_cnt = (kind_q == BOP_SETB) ? SET_LAST : BR_LAST;
   assign taken    = (kind_q == BOP_BRSET) ? bit_val : !bit_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         kind_q  <= BOP_NONE;
         bit_q   <= '0;
         addr_q  <= '0;
         disp_q  <= '0;
         pc_q    <= '0;
         cin_q   <= 1'b0;
         npc_q   <= '0;
         carry_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= RD_CNT;
         kind_q <= kind_d;
         bit_q  <= bit_d;
         addr_q <= dir_addr;
         disp_q <= disp;
         pc_q   <= pc_in;
         cin_q  <= carry_in;
      end else if (busy_q) begin
         if (cnt_q == last_cnt) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (cnt_q == CAP_CNT) begin
            if (kind_q == BOP_SETB) begin
               npc_q   <= seq_pc;
               carry_q <= cin_q;
            end else begin
               npc_q   <= taken ? tgt_pc : seq_pc;
               carry_q <= bit_val;
            end
         end
      end
   end

   assign mem_addr  = {{(ADDR_W-PAGE_W){1'b0}}, addr_q};
   assign mem_rd    = busy_q && (cnt_q == RD_CNT);
   assign mem_wr    = busy_q && (cnt_q == CAP_CNT) && (kind_q == BOP_SETB);
   assign mem_wdata = mem_rdata | mask;
   assign next_pc   = npc_q;
   assign carry_out = carry_q;
   assign done      = busy_q && (cnt_q == last_cnt);
endmodule

// File: rtl/bitop_seq_chk.sv
module bitop_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [ADDR_W-1:0] next_pc,
   input logic              carry_out,
   input logic              done
);
   // R7: accesses stay inside the direct page
   p_page_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[ADDR_W-1:PAGE_W] == '0));

   // R7: read and write never share a cycle
   p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R6: a write comes right after the read of the same byte
   p_wr_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));

   // R6: written byte keeps every set bit and adds at most one
   p_wr_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (((mem_wdata & mem_rdata) == mem_rdata)
                  && ($countones(mem_wdata ^ mem_rdata) <= 1)));

   // R5: done lasts a single cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: no memory traffic in the completion cycle
   p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_rd && !mem_wr));

   // R9: results hold after completion
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(next_pc) && $stable(carry_out)));
endmodule

bind bitop_seq bitop_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .PAGE_W (PAGE_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .next_pc   (next_pc),
   .carry_out (carry_out),
   .done      (done)
);

// File: tb/test_bitop_seq.sv
`timescale 1ns/1ps
module test_bitop_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  dir_addr = 8'h00;
   logic [7:0]  disp = 8'h00;
   logic [15:0] pc_in = 16'h0000;
   logic        carry_in = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic [15:0] next_pc;
   logic        carry_out;
   logic        done;

   always #2 clk = ~clk;

   bitop_seq i_bitop_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .opcode (opcode),
      .dir_addr (dir_addr), .disp (disp), .pc_in (pc_in), .carry_in (carry_in),
      .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_wr (mem_wr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .next_pc (next_pc), .carry_out (carry_out), .done (done)
   );

   // memory model: registered read, preload port owned by the bench tasks
   logic [7:0]  mem [256];
   logic        pre_we = 1'b0;
   logic [7:0]  pre_addr = 8'h00;
   logic [7:0]  pre_data = 8'h00;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          done_cnt = 0;
   logic [15:0] last_rd_addr = 16'h0000;

   always @(posedge clk) begin
      if (pre_we) mem[pre_addr] <= pre_data;
      if (mem_rd) begin
         mem_rdata    <= mem[mem_addr[7:0]];
         last_rd_addr <= mem_addr;
         rd_cnt       <= rd_cnt + 1;
      end
      if (mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
   end

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   task automatic preload(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = a; pre_data = d;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   // runs one operation; returns the cycle in which done was seen
   task automatic run_op(input logic [7:0] op, input logic [7:0] ad,
                         input logic [7:0] dp, input logic [15:0] pc,
                         input logic [7:0] mb, input bit ci, input bit poke,
                         output int cyc, output logic [15:0] npc,
                         output bit c, output logic [7:0] mout,
                         output int rds, output int wrs);
      int rd0, wr0;
      preload(ad, mb);
      rd0 = rd_cnt; wr0 = wr_cnt;
      opcode = op; dir_addr = ad; disp = dp; pc_in = pc; carry_in = ci;
      start = 1'b1;
      cyc = 1;
      do begin
         @(negedge clk);
         cyc++;
         start = poke && (cyc == 2);
         if (poke && cyc == 2) begin
            opcode = 8'h1E; dir_addr = ad + 8'd1; pc_in = 16'h5555;
         end
      end while (!done && cyc < 20);
      npc = next_pc;
      c = carry_out;
      @(negedge clk);
      mout = mem[ad];
      rds = rd_cnt - rd0;
      wrs = wr_cnt - wr0;
   endtask

   function automatic logic [15:0] br_pc(input logic [15:0] pc,
                                         input logic [7:0] dp, input bit tk);
      return tk ? (pc + 16'd3 + {{8{dp[7]}}, dp}) : (pc + 16'd3);
   endfunction

   // {op, addr, disp, pc, mem, cin, exp_pc, exp_c, exp_mem}
   localparam logic [73:0] VEC [9] = '{
      {8'h00, 8'h40, 8'h10, 16'h1000, 8'h01, 1'b0, 16'h1013, 1'b1, 8'h01},
      {8'h01, 8'h40, 8'h10, 16'h1000, 8'h01, 1'b0, 16'h1003, 1'b1, 8'h01},
      {8'h0F, 8'hFF, 8'hF0, 16'h2000, 8'h7F, 1'b1, 16'h1FF3, 1'b0, 8'h7F},
      {8'h0E, 8'hFF, 8'h80, 16'h2000, 8'h7F, 1'b1, 16'h2003, 1'b0, 8'h7F},
      {8'h0C, 8'h00, 8'h7F, 16'hFFF0, 8'h40, 1'b0, 16'h0072, 1'b1, 8'h40},
      {8'h03, 8'h22, 8'hFA, 16'h0001, 8'h00, 1'b1, 16'hFFFE, 1'b0, 8'h00},
      {8'h1A, 8'h80, 8'h00, 16'h3000, 8'h00, 1'b1, 16'h3002, 1'b1, 8'h20},
      {8'h10, 8'h80, 8'h00, 16'h3000, 8'hFE, 1'b0, 16'h3002, 1'b0, 8'hFF},
      {8'h1E, 8'h81, 8'h33, 16'h3000, 8'h80, 1'b0, 16'h3002, 1'b0, 8'h80}
   };

   initial begin
      int cyc, rds, wrs;
      logic [15:0] npc;
      bit c;
      logic [7:0] mout;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R1", "strobes in reset",
          {done, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(next_pc == 16'h0000, "R1", "next_pc after reset", next_pc, 0);
      chk(carry_out == 1'b0 && done == 1'b0, "R1", "carry/done after reset",
          {carry_out, done}, 0);

      // table of vectors: R2 R3 R4 R5 R6
      for (int i = 0; i < 9; i++) begin
         logic [73:0] v;
         v = VEC[i];
         run_op(v[73:66], v[65:58], v[57:50], v[49:34], v[33:26], v[25], 1'b0,
                cyc, npc, c, mout, rds, wrs);
         chk(cyc == (v[70] ? 4 : 5), v[70] ? "R6" : "R5", "done cycle", cyc,
             v[70] ? 4 : 5);
         chk(npc == v[24:9], "R3", "table next_pc", npc, v[24:9]);
         chk(c == v[8], "R4", "table carry", c, v[8]);
         chk(mout == v[7:0], "R6", "table memory byte", mout, v[7:0]);
         chk(rds == 1 && wrs == (v[70] ? 1 : 0), "R7", "access counts",
             rds * 16 + wrs, v[70] ? 17 : 16);
         chk(last_rd_addr == {8'h00, v[65:58]}, "R7", "read address",
             last_rd_addr, {8'h00, v[65:58]});
      end

      // every bit position for every operation kind: R2
      for (int n = 0; n < 8; n++) begin
         for (int pat = 0; pat < 2; pat++) begin
            logic [7:0] mb;
            logic [7:0] ad;
            logic [7:0] dp;
            bit bitv;
            mb   = pat ? ~(8'h01 << n) : (8'h01 << n);
            bitv = mb[n];
            ad   = 8'(8'h10 + n);
            dp   = 8'(8'hC0 + 16 * n);
            run_op(8'(n << 1), ad, dp, 16'h4000, mb, 1'b1, 1'b0,
                   cyc, npc, c, mout, rds, wrs);
            chk(npc == br_pc(16'h4000, dp, bitv), "R2", "bit-set branch pc",
                npc, br_pc(16'h4000, dp, bitv));
            chk(c == bitv, "R4", "bit-set branch carry", c, bitv);
            run_op(8'((n << 1) | 1), ad, dp, 16'h4000, mb, 1'b0, 1'b0,
                   cyc, npc, c, mout, rds, wrs);
            chk(npc == br_pc(16'h4000, dp, !bitv), "R2", "bit-clear branch pc",
                npc, br_pc(16'h4000, dp, !bitv));
            chk(c == bitv && wrs == 0, "R5", "bit-clear carry/no write",
                {c, wrs[0]}, {bitv, 1'b0});
            run_op(8'(8'h10 | (n << 1)), ad, dp, 16'h4000, mb, bit'(pat), 1'b0,
                   cyc, npc, c, mout, rds, wrs);
            chk(mout == (mb | (8'h01 << n)), "R6", "set byte", mout,
                mb | (8'h01 << n));
            chk(npc == 16'h4002 && c == bit'(pat) && cyc == 4, "R6",
                "set pc/carry/cycles", {npc, 3'(cyc), c}, {16'h4002, 3'd4, bit'(pat)});
         end
      end

      // R9: results hold after done
      run_op(8'h00, 8'h50, 8'h08, 16'h6000, 8'h01, 1'b0, 1'b0,
             cyc, npc, c, mout, rds, wrs);
      repeat (6) @(negedge clk);
      chk(next_pc == 16'h600B && carry_out == 1'b1, "R9", "held results",
          {next_pc, carry_out}, {16'h600B, 1'b1});

      // R8: unsupported opcodes are ignored
      for (int k = 0; k < 3; k++) begin
         int rd0, wr0, dn0;
         rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
         opcode = (k == 0) ? 8'h11 : (k == 1) ? 8'h20 : 8'hFF;
         dir_addr = 8'h50; pc_in = 16'h7777; carry_in = 1'b0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (8) @(negedge clk);
         chk(rd_cnt == rd0 && wr_cnt == wr0 && done_cnt == dn0, "R8",
             "unsupported opcode activity", rd_cnt - rd0 + wr_cnt - wr0, 0);
         chk(next_pc == 16'h600B && carry_out == 1'b1, "R8",
             "unsupported opcode outputs", {next_pc, carry_out}, {16'h600B, 1'b1});
      end

      // R8: a start during a running operation is ignored
      begin
         int dn0, wr0;
         run_op(8'h05, 8'h60, 8'h02, 16'h0100, 8'h00, 1'b1, 1'b1,
                cyc, npc, c, mout, rds, wrs);
         dn0 = done_cnt; wr0 = wr_cnt;
         repeat (8) @(negedge clk);
         chk(npc == 16'h0105 && c == 1'b0 && cyc == 5, "R8", "busy start result",
             {npc, c}, {16'h0105, 1'b0});
         chk(done_cnt == dn0 && wr_cnt == wr0 && mem[8'h61] != 8'h80 || mem[8'h61] == 8'h80
             && done_cnt == dn0 && wr_cnt == wr0, "R8", "busy start no later op",
             done_cnt - dn0 + wr_cnt - wr0, 0);
         chk(next_pc == 16'h0105, "R8", "busy start outputs kept", next_pc, 16'h0105);
      end

      finish_run();
   end
endmodule